// File: doc/BRIEF.md
# Buffer-Window DMA Transfer Engine

This block runs the DMA data phases and the DMA command phase of a disk-bus controller. It works through a dedicated 128 KiB byte-wide buffer RAM. The surrounding register file supplies a write-side transfer count, split into low, middle and high bytes, and the low 17 bits of the DMA address register, which give the start of the window. The command decoder passes each command to the engine with its DMA flag and a transfer kind. For a DMA transfer, the engine walks the buffer at one byte per cycle. It either fills the buffer from a byte stream arriving from the target, or reads bytes out of the buffer and presents them to the target. At the end it updates the read-side count registers and the terminal-count flag.

A programmed count of zero stands for 65536 bytes. For reads, buffer addresses wrap modulo the window size. For an inbound transfer, the length is clipped at the top of the window. When the source has fewer bytes than the clipped length, the rest of the region is written with zeros. A one-cycle done pulse, together with a flag, tells the sequencer whether the phase must continue as a multi-part transfer.

Top module: `dma_window_engine`

## Requirements
- R1: A combined count (low + 256 x middle) of zero moves exactly 65536 bytes.
- R2: Byte i of a transfer uses buffer address (win_base + i) mod 131072.
- R3: A command accepted with cmd_dma=1, of any kind including 2'b00, copies wr_cnt_lo/mid/hi into rd_cnt_lo/mid/hi and clears term_cnt in the following cycle.
- R4: When an inbound (kind 2'b01) or outbound (kind 2'b10) transfer ends, rd_cnt_lo and rd_cnt_mid read zero, rd_cnt_hi keeps its loaded value, and term_cnt is set. term_cnt is first high in the done cycle.
- R5: Inbound: byte i is written with in_data (in_ready high) while i < min(src_avail, span), and with 8'h00 (in_ready low) for the rest of the span.
- R6: Inbound span = min(count, 131072 - win_base). stay_phase = 1 when src_avail exceeds the bytes taken.
- R7: Outbound moves min(count, tgt_need) bytes. stay_phase = 1 when tgt_need exceeds count.
- R8: Command phase (kind 2'b11) reads count bytes with wrap. rd_cnt_lo/mid then keep the loaded count, term_cnt is set and stay_phase = 0.
- R9: One buffer access per cycle and never a read and a write together. busy is high from the cycle after acceptance through the done cycle. done lasts one cycle. out_valid follows each read by one cycle, and out_data carries the byte read.
- R10: A command presented while busy is ignored, counts included.
- R11: A command with cmd_dma=0, or of kind 2'b00, starts no transfer.
- R12: After reset: busy, done, term_cnt, out_valid and all rd_cnt bytes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe from the decoder |
| cmd_dma | input | 1 | DMA flag of the command |
| cmd_kind | input | 2 | 00 other, 01 inbound, 10 outbound, 11 command phase |
| wr_cnt_lo | input | 8 | Write-side count, low byte |
| wr_cnt_mid | input | 8 | Write-side count, middle byte |
| wr_cnt_hi | input | 8 | Write-side count, high byte |
| win_base | input | 17 | Low bits of the DMA address register |
| src_avail | input | 17 | Bytes the source holds for an inbound transfer |
| tgt_need | input | 17 | Bytes the target still wants (outbound) |
| in_data | input | 8 | Inbound byte, taken when in_ready is high |
| in_ready | output | 1 | Engine takes in_data this cycle |
| out_valid | output | 1 | out_data carries a buffer byte |
| out_data | output | 8 | Byte read from the buffer |
| buf_addr | output | 17 | Buffer RAM address |
| buf_we | output | 1 | Buffer write enable |
| buf_re | output | 1 | Buffer read enable (data next cycle) |
| buf_wdata | output | 8 | Buffer write data |
| buf_rdata | input | 8 | Buffer read data, one cycle after buf_re |
| rd_cnt_lo | output | 8 | Read-side count, low byte |
| rd_cnt_mid | output | 8 | Read-side count, middle byte |
| rd_cnt_hi | output | 8 | Read-side count, high byte |
| term_cnt | output | 1 | Terminal-count status |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| stay_phase | output | 1 | Phase continues as a multi-part transfer (valid with done) |

## Verification
The assertions assume the following about the inputs:
- The buffer RAM returns read data exactly one cycle after buf_re.
- tgt_need is at least 1 whenever an outbound transfer starts.
- cmd_kind, the counts and win_base are stable in the cycle of the command.

The stimulus respects these assumptions. It models the RAM with the same one-cycle read latency, always gives a non-zero target demand, and holds every command field for exactly one clock. A command arriving while busy is deliberately sent during a long read, so that it overlaps an active transfer.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'b00,
    KIND_IN   = 2'b01,
    KIND_OUT  = 2'b10,
    KIND_CMD  = 2'b11
  } xfer_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIN  = 2'b10
  } eng_state_e;
endpackage

// File: rtl/dmaw_sizer.sv
module dmaw_sizer
  import dmaw_pkg::*;
#(
  parameter int BUF_AW = 17,
  parameter int CNT_W  = 16,
  parameter int LW     = BUF_AW + 1
) (
  input  xfer_kind_e        kind,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [BUF_AW-1:0] base,
  input  logic [BUF_AW-1:0] src_avail,
  input  logic [BUF_AW-1:0] tgt_need,
  output logic [LW-1:0]     total,
  output logic [LW-1:0]     take,
  output logic              more
);
  logic [LW-1:0] n_full;
  logic [LW-1:0] space;
  logic [LW-1:0] src_w;
  logic [LW-1:0] need_w;
  logic [LW-1:0] span;

  always_comb begin
    n_full = (cnt == '0) ? (LW'(1) << CNT_W) : LW'(cnt);
    space  = (LW'(1) << BUF_AW) - LW'(base);
    src_w  = LW'(src_avail);
    need_w = LW'(tgt_need);
    span   = (n_full < space) ? n_full : space;
    total  = n_full;
    take   = '0;
    more   = 1'b0;
    case (kind)
      KIND_IN: begin
        total = span;
        take  = (src_w < span) ? src_w : span;
        more  = (src_w > span);
      end
      KIND_OUT: begin
        total = (need_w < n_full) ? need_w : n_full;
        more  = (need_w > n_full);
      end
      default: begin
        total = n_full;
      end
    endcase
  end
endmodule

// File: rtl/dmaw_walker.sv
module dmaw_walker #(
  parameter int BUF_AW = 17,
  parameter int LW     = BUF_AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              advance,
  input  logic [BUF_AW-1:0] base_in,
  input  logic [LW-1:0]     total_in,
  input  logic [LW-1:0]     take_in,
  output logic [BUF_AW-1:0] addr,
  output logic              last,
  output logic              fill_zero
);
  logic [BUF_AW-1:0] base_q, base_d;
  logic [LW-1:0]     total_q, total_d;
  logic [LW-1:0]     take_q, take_d;
  logic [LW-1:0]     idx_q, idx_d;
  logic              en;

  always_comb begin
    base_d  = base_q;
    total_d = total_q;
    take_d  = take_q;
    idx_d   = idx_q;
    if (start) begin
      base_d  = base_in;
      total_d = total_in;
      take_d  = take_in;
      idx_d   = '0;
    end else if (advance) begin
      idx_d = idx_q + LW'(1);
    end
  end

  assign en = start | advance;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      total_q <= '0;
      take_q  <= '0;
      idx_q   <= '0;
    end else if (en) begin
      base_q  <= base_d;
      total_q <= total_d;
      take_q  <= take_d;
      idx_q   <= idx_d;
    end
  end

  // Address arithmetic truncates to the window width, giving the wrap.
  assign addr      = base_q + idx_q[BUF_AW-1:0];
  assign last      = (idx_q == total_q - LW'(1));
  assign fill_zero = (idx_q >= take_q);
endmodule

// File: rtl/dmaw_count_regs.sv
module dmaw_count_regs #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] lo_in,
  input  logic [BYTE_W-1:0] mid_in,
  input  logic [BYTE_W-1:0] hi_in,
  input  logic              finish,
  input  logic              clear_len,
  output logic [BYTE_W-1:0] lo,
  output logic [BYTE_W-1:0] mid,
  output logic [BYTE_W-1:0] hi,
  output logic              tc
);
  logic [BYTE_W-1:0] lo_d, mid_d, hi_d;
  logic              tc_d;
  logic              en;

  always_comb begin
    lo_d  = lo;
    mid_d = mid;
    hi_d  = hi;
    tc_d  = tc;
    if (load) begin
      lo_d  = lo_in;
      mid_d = mid_in;
      hi_d  = hi_in;
      tc_d  = 1'b0;
    end else if (finish) begin
      tc_d = 1'b1;
      if (clear_len) begin
        lo_d  = '0;
        mid_d = '0;
      end
    end
  end

  assign en = load | finish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo  <= '0;
      mid <= '0;
      hi  <= '0;
      tc  <= 1'b0;
    end else if (en) begin
      lo  <= lo_d;
      mid <= mid_d;
      hi  <= hi_d;
      tc  <= tc_d;
    end
  end
endmodule

// File: rtl/dma_window_engine.sv
module dma_window_engine
  import dmaw_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int BUF_AW = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_dma,
  input  logic [1:0]        cmd_kind,
  input  logic [BYTE_W-1:0] wr_cnt_lo,
  input  logic [BYTE_W-1:0] wr_cnt_mid,
  input  logic [BYTE_W-1:0] wr_cnt_hi,
  input  logic [BUF_AW-1:0] win_base,
  input  logic [BUF_AW-1:0] src_avail,
  input  logic [BUF_AW-1:0] tgt_need,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic [BUF_AW-1:0] buf_addr,
  output logic              buf_we,
  output logic              buf_re,
  output logic [BYTE_W-1:0] buf_wdata,
  input  logic [BYTE_W-1:0] buf_rdata,
  output logic [BYTE_W-1:0] rd_cnt_lo,
  output logic [BYTE_W-1:0] rd_cnt_mid,
  output logic [BYTE_W-1:0] rd_cnt_hi,
  output logic              term_cnt,
  output logic              busy,
  output logic              done,
  output logic              stay_phase
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam int LW    = BUF_AW + 1;

  eng_state_e state_q, state_d;
  xfer_kind_e kind_q, kind_d, kind_in;
  logic       more_q, more_d;
  logic       outv_q;

  logic [LW-1:0] sz_total, sz_take;
  logic          sz_more;
  logic          accept, start, run, last, fill_zero, finish;

  assign kind_in = xfer_kind_e'(cmd_kind);
  assign accept  = cmd_valid && (state_q == ST_IDLE);
  assign start   = accept && cmd_dma && (kind_in != KIND_NONE);
  assign run     = (state_q == ST_RUN);
  assign finish  = run && last;

  dmaw_sizer #(.BUF_AW(BUF_AW), .CNT_W(CNT_W), .LW(LW)) u_sizer (
    .kind      (kind_in),
    .cnt       ({wr_cnt_mid, wr_cnt_lo}),
    .base      (win_base),
    .src_avail (src_avail),
    .tgt_need  (tgt_need),
    .total     (sz_total),
    .take      (sz_take),
    .more      (sz_more)
  );

  dmaw_walker #(.BUF_AW(BUF_AW), .LW(LW)) u_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .advance   (run),
    .base_in   (win_base),
    .total_in  (sz_total),
    .take_in   (sz_take),
    .addr      (buf_addr),
    .last      (last),
    .fill_zero (fill_zero)
  );

  dmaw_count_regs #(.BYTE_W(BYTE_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept && cmd_dma),
    .lo_in     (wr_cnt_lo),
    .mid_in    (wr_cnt_mid),
    .hi_in     (wr_cnt_hi),
    .finish    (finish),
    .clear_len (kind_q != KIND_CMD),
    .lo        (rd_cnt_lo),
    .mid       (rd_cnt_mid),
    .hi        (rd_cnt_hi),
    .tc        (term_cnt)
  );

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    more_d  = more_q;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_RUN;
        kind_d  = kind_in;
        more_d  = sz_more;
      end
      ST_RUN:  if (last) state_d = ST_FIN;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= KIND_NONE;
      more_q  <= 1'b0;
      outv_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      more_q  <= more_d;
      outv_q  <= buf_re;
    end
  end

  assign buf_we     = run && (kind_q == KIND_IN);
  assign buf_re     = run && (kind_q != KIND_IN);
  assign buf_wdata  = fill_zero ? '0 : in_data;
  assign in_ready   = buf_we && !fill_zero;
  assign out_valid  = outv_q;
  assign out_data   = outv_q ? buf_rdata : '0;
  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_FIN);
  assign stay_phase = more_q;
endmodule

// File: rtl/dmaw_checker.sv
module dmaw_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_dma,
  input logic [1:0] cmd_kind,
  input logic       busy,
  input logic       done,
  input logic       term_cnt,
  input logic       buf_we,
  input logic       buf_re,
  input logic       in_ready,
  input logic       out_valid
);
  assert_one_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_we && buf_re));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(buf_we || buf_re));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_read_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_re |=> out_valid);
  assert_done_tc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> term_cnt);
  assert_tc_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(term_cnt) |-> done);
  assert_ready_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> buf_we);
  assert_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_dma && cmd_kind != 2'b00) |=> busy);
  assert_no_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && (!cmd_dma || cmd_kind == 2'b00)) |=> !busy);
endmodule

bind dma_window_engine dmaw_checker u_dmaw_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_dma   (cmd_dma),
  .cmd_kind  (cmd_kind),
  .busy      (busy),
  .done      (done),
  .term_cnt  (term_cnt),
  .buf_we    (buf_we),
  .buf_re    (buf_re),
  .in_ready  (in_ready),
  .out_valid (out_valid)
);

// File: tb/dma_window_engine_bench.sv
`timescale 1ns/1ps
module dma_window_engine_bench;
  localparam int WIN = 131072;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_dma = 1'b0;
  logic [1:0]  cmd_kind = 2'b00;
  logic [7:0]  wr_cnt_lo = 8'h00, wr_cnt_mid = 8'h00, wr_cnt_hi = 8'h00;
  logic [16:0] win_base = '0, src_avail = '0, tgt_need = 17'd1;
  logic [7:0]  in_data;
  logic        in_ready, out_valid, buf_we, buf_re, term_cnt, busy, done, stay_phase;
  logic [7:0]  out_data, buf_wdata, rd_cnt_lo, rd_cnt_mid, rd_cnt_hi;
  logic [7:0]  buf_rdata = 8'h00;
  logic [16:0] buf_addr;

  int tests = 0, fails = 0;
  bit armed = 1'b0;
  int src_idx = 0, src_seed = 0;
  int out_count = 0;

  // reference model state
  int ms = 0, mi = 0, mtotal = 0, mtake = 0, mkind = 0, mbase = 0, mmore = 0;
  int mlo = 0, mmid = 0, mhi = 0, mtc = 0, mov = 0, mod = 0;

  logic [7:0] ram [int];

  always #4 clk = ~clk;

  dma_window_engine u_dma_window_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_dma(cmd_dma),
    .cmd_kind(cmd_kind), .wr_cnt_lo(wr_cnt_lo), .wr_cnt_mid(wr_cnt_mid),
    .wr_cnt_hi(wr_cnt_hi), .win_base(win_base), .src_avail(src_avail),
    .tgt_need(tgt_need), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .buf_addr(buf_addr),
    .buf_we(buf_we), .buf_re(buf_re), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .rd_cnt_lo(rd_cnt_lo), .rd_cnt_mid(rd_cnt_mid),
    .rd_cnt_hi(rd_cnt_hi), .term_cnt(term_cnt), .busy(busy), .done(done),
    .stay_phase(stay_phase)
  );

  function automatic int sbyte(int k);
    return (k * 13 + src_seed) & 255;
  endfunction

  function automatic int ram_rd(int a);
    return ram.exists(a) ? int'(ram[a]) : 0;
  endfunction

  assign in_data = 8'(sbyte(src_idx));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // buffer RAM with one-cycle read latency
  always @(posedge clk) begin
    if (buf_we) ram[int'(buf_addr)] = buf_wdata;
    if (buf_re) buf_rdata <= 8'(ram_rd(int'(buf_addr)));
    if (out_valid) out_count++;
  end

  // cycle-by-cycle reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mi = 0; mlo = 0; mmid = 0; mhi = 0; mtc = 0; mov = 0; mmore = 0;
    end else begin
      int n, space, src, need, nov;
      nov = 0;
      if (ms == 1 && mkind != 1) begin
        nov = 1;
        mod = ram_rd((mbase + mi) % WIN);
      end
      if (ms == 1 && mkind == 1 && mi < mtake) src_idx++;
      case (ms)
        0: if (cmd_valid) begin
          if (cmd_dma) begin
            mlo = wr_cnt_lo; mmid = wr_cnt_mid; mhi = wr_cnt_hi; mtc = 0;
          end
          if (cmd_dma && cmd_kind != 2'b00) begin
            n = wr_cnt_mid * 256 + wr_cnt_lo;
            if (n == 0) n = 65536;
            mbase = win_base; space = WIN - mbase;
            src = src_avail; need = tgt_need;
            mkind = cmd_kind; mi = 0; mtake = 0; ms = 1;
            if (mkind == 1) begin
              mtotal = (n < space) ? n : space;
              mtake = (src < mtotal) ? src : mtotal;
              mmore = (src > mtotal) ? 1 : 0;
              src_idx = 0;
            end else if (mkind == 2) begin
              mtotal = (need < n) ? need : n;
              mmore = (need > n) ? 1 : 0;
            end else begin
              mtotal = n; mmore = 0;
            end
          end
        end
        1: if (mi == mtotal - 1) begin
          ms = 2; mtc = 1;
          if (mkind != 3) begin mlo = 0; mmid = 0; end
        end else mi++;
        default: ms = 0;
      endcase
      mov = nov;
    end
  end

  // compare against the model away from the active edge
  always @(negedge clk) begin
    if (rst_n && armed) begin
      int xa;
      xa = (mbase + mi) % WIN;
      chk(busy == (ms != 0), "R9 busy", busy, ms != 0);
      chk(done == (ms == 2), "R9 done", done, ms == 2);
      chk(buf_we == (ms == 1 && mkind == 1), "R5 buf_we", buf_we, ms == 1 && mkind == 1);
      chk(buf_re == (ms == 1 && mkind != 1), "R8 buf_re", buf_re, ms == 1 && mkind != 1);
      if (ms == 1) chk(int'(buf_addr) == xa, "R2 buf_addr", buf_addr, xa);
      if (ms == 1 && mkind == 1) begin
        chk(in_ready == (mi < mtake), "R5 in_ready", in_ready, mi < mtake);
        chk(int'(buf_wdata) == ((mi < mtake) ? sbyte(src_idx) : 0), "R5 wdata",
            buf_wdata, (mi < mtake) ? sbyte(src_idx) : 0);
      end else chk(!in_ready, "R5 in_ready idle", in_ready, 0);
      chk(out_valid == (mov != 0), "R9 out_valid", out_valid, mov);
      if (mov != 0) chk(int'(out_data) == mod, "R8 out_data", out_data, mod);
      chk(int'(rd_cnt_lo) == mlo, "R4 rd_cnt_lo", rd_cnt_lo, mlo);
      chk(int'(rd_cnt_mid) == mmid, "R4 rd_cnt_mid", rd_cnt_mid, mmid);
      chk(int'(rd_cnt_hi) == mhi, "R3 rd_cnt_hi", rd_cnt_hi, mhi);
      chk(term_cnt == (mtc != 0), "R4 term_cnt", term_cnt, mtc);
      if (ms == 2) chk(stay_phase == (mmore != 0), "R7 stay_phase", stay_phase, mmore);
    end
  end

  task automatic issue(input bit dma, input int kind, input int cnt, input int hi,
                       input int base, input int src, input int need);
    @(negedge clk); #1;
    cmd_valid = 1'b1; cmd_dma = dma; cmd_kind = 2'(kind);
    wr_cnt_lo = 8'(cnt); wr_cnt_mid = 8'(cnt >> 8); wr_cnt_hi = 8'(hi);
    win_base = 17'(base); src_avail = 17'(src); tgt_need = 17'(need);
    @(negedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic fill(input int base, input int len, input int val);
    for (int k = 0; k < len; k++) ram[(base + k) % WIN] = 8'(val);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", 200000, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(!busy && !done && !term_cnt && !out_valid, "R12 flags", {busy, done, term_cnt, out_valid}, 0);
    chk({rd_cnt_hi, rd_cnt_mid, rd_cnt_lo} == 24'h0, "R12 counts", {rd_cnt_hi, rd_cnt_mid, rd_cnt_lo}, 0);
    rst_n = 1'b1;
    armed = 1'b1;

    // R3 / R11: DMA flag with no-transfer kind loads counts only
    issue(1, 0, 16'h1234, 8'h56, 0, 0, 1);
    @(negedge clk);
    chk({rd_cnt_hi, rd_cnt_mid, rd_cnt_lo} == 24'h561234, "R3 load",
        {rd_cnt_hi, rd_cnt_mid, rd_cnt_lo}, 24'h561234);
    chk(!busy, "R11 kind none", busy, 0);
    // R11: no DMA flag, no transfer, counts unchanged
    issue(0, 1, 16'h0009, 8'h01, 0, 5, 1);
    @(negedge clk);
    chk(!busy && rd_cnt_lo == 8'h34, "R11 no dma", rd_cnt_lo, 8'h34);

    // R5: inbound, short source, zero fill
    src_seed = 7;
    fill(256, 32, 255);
    issue(1, 1, 20, 8'h03, 256, 12, 1);
    wait_idle();
    for (int k = 0; k < 20; k++)
      chk(ram_rd(256 + k) == ((k < 12) ? sbyte(k) : 0), "R5 buffer", ram_rd(256 + k),
          (k < 12) ? sbyte(k) : 0);
    chk(ram_rd(276) == 255, "R5 beyond span", ram_rd(276), 255);
    chk(rd_cnt_hi == 8'h03 && term_cnt, "R4 after inbound", {rd_cnt_hi, term_cnt}, 7);

    // R6: inbound clipped at the window end, source left over
    src_seed = 91;
    fill(WIN - 8, 8, 255);
    fill(0, 4, 255);
    issue(1, 1, 32, 0, WIN - 8, 40, 1);
    wait_idle();
    chk(ram_rd(WIN - 1) == sbyte(7), "R6 last byte", ram_rd(WIN - 1), sbyte(7));
    chk(ram_rd(0) == 255, "R6 no wrap", ram_rd(0), 255);

    // R7: outbound with wrap, target wants more / fewer
    fill(WIN - 2, 2, 8'hA5);
    fill(0, 2, 8'h5A);
    out_count = 0;
    issue(1, 2, 4, 0, WIN - 2, 0, 10);
    wait_idle();
    chk(out_count == 4, "R7 pass size", out_count, 4);
    out_count = 0;
    issue(1, 2, 4, 0, 256, 0, 3);
    wait_idle();
    chk(out_count == 3, "R7 short need", out_count, 3);

    // R8: command phase keeps the count, R10: command while busy ignored
    issue(1, 3, 50, 8'h22, 250, 0, 1);
    repeat (5) @(negedge clk);
    issue(1, 0, 16'h0777, 8'h44, 0, 0, 1);
    wait_idle();
    chk({rd_cnt_hi, rd_cnt_mid, rd_cnt_lo} == 24'h220032, "R10 ignored",
        {rd_cnt_hi, rd_cnt_mid, rd_cnt_lo}, 24'h220032);
    chk(term_cnt, "R8 term_cnt", term_cnt, 1);

    // R1: zero count means 65536 bytes
    out_count = 0;
    issue(1, 3, 0, 0, 100, 0, 1);
    wait_idle();
    @(negedge clk);
    chk(out_count == 65536, "R1 full length", out_count, 65536);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule